// File: doc/BRIEF.md
# Nine-bit three-wire display serializer

This block drives a display controller over a three-wire serial link made of a chip select, a serial clock and one data line, with no separate pin to tell commands from data. Every byte leaves the block as a nine-bit word. The first bit of each word is a tag that marks the byte as a command or as data. The tag is followed by the eight payload bits.

Bytes enter through a ready/valid port. Each byte carries a command/data tag, and a last flag closes the burst. The words go out as one continuous bit stream under a single chip-select window. Nine-bit words seldom end on a byte boundary, so after the last byte the block appends filler command words until the bit count is a whole number of bytes. The filler opcode comes from an input, because the harmless opcode differs from one controller to another. A typical burst is one command byte followed by its argument bytes (up to 16 bytes in all), or a run of up to 128 data bytes.

Top module: `nbw3_serializer`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Each accepted byte is sent as a 9-bit word. The tag bit goes first, then the payload from bit 7 down to bit 0. Each bit is valid at the rising edge of `sclk`.
- R3: The tag bit equals `in_is_data`: 0 for a command byte and 1 for a data byte.
- R4: After the byte flagged with `in_last`, filler words are appended until the number of bits in the chip-select window is a multiple of 8. Each filler word is a tag of 0 followed by `filler_op`. For n words, exactly (8 − n mod 8) mod 8 filler words are added, so never more than 7.
- R5: A burst whose word count is a multiple of 8 (for example 8 words, 72 bits) gets no filler words.
- R6: `cs_n` falls before the first rising edge of `sclk` in a burst. It stays low for the whole burst, including any gaps between bytes, and rises only while `sclk` is low, after the last filler bit. Each burst gives exactly one low window.
- R7: The link uses SPI mode 0. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. Each high phase of `sclk` lasts ceil(CLK_HZ / (2·SCLK_MAX_HZ)) system clocks, which is 13 at the default settings.
- R8: `in_ready` is 0 while a word is being shifted, while filler words are being sent and while chip select is closing.
- R9: `busy` is 1 exactly while `cs_n` is 0.
- R10: The filler words carry the value on `filler_op` at the time they are sent, so changing that input between bursts changes the padding.
- R11: Between two words of a burst that is not finished, `in_ready` is 1 and `cs_n` stays 0 for as long as the source takes to present the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filler_op | input | BYTE_W | Opcode used in padding command words |
| in_valid | input | 1 | Byte present on the input |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | BYTE_W | Payload byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Byte closes the burst |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the display |
| busy | output | 1 | Chip-select window open |

## Verification
Two events can land on the same system clock edge. The falling `sclk` edge that ends the last payload word is also the edge on which the first filler word is loaded. Likewise, the falling edge that ends a filler word can be the edge on which chip-select closing starts. The bench provokes both with bursts of 1, 3 and 20 words, which need 7, 5 and 4 filler words. It also sends a burst of exactly 8 words, where the closing must start with no filler at all. Each case is judged on the captured bit stream, bit by bit and by total length, against an expected stream built from the tags, the bytes and the filler opcode.

// File: rtl/nbw3_pkg.sv
package nbw3_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2,
      ST_CLOSE = 2'd3
   } nbw3_state_e;

   // system clocks per serial clock level, rounded up so the link never exceeds its limit
   function automatic int half_cycles(input int clk_hz, input int sclk_hz);
      longint num;
      num = longint'(clk_hz) + 2 * longint'(sclk_hz) - 1;
      return int'(num / (2 * longint'(sclk_hz)));
   endfunction

endpackage

// File: rtl/nbw3_tick.sv
module nbw3_tick #(
   parameter int HALF = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF <= 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;
         assign tick = run && (cnt_q == CW'(HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (!run)     cnt_q <= '0;
            else if (tick)     cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/nbw3_shifter.sv
module nbw3_shifter #(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              tick,
   output logic              active,
   output logic              word_done,
   output logic              sclk,
   output logic              mosi
);
   localparam int BW = $clog2(WORD_W);

   logic [WORD_W-1:0] sreg_q;
   logic [BW-1:0]     bcnt_q;
   logic              sclk_q;
   logic              act_q;
   logic              last_bit;

   assign last_bit  = (bcnt_q == BW'(WORD_W - 1));
   assign word_done = act_q && tick && sclk_q && last_bit;
   assign active    = act_q;
   assign sclk      = sclk_q;
   assign mosi      = sreg_q[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         bcnt_q <= '0;
         sclk_q <= 1'b0;
         act_q  <= 1'b0;
      end else if (load) begin
         sreg_q <= load_word;
         bcnt_q <= '0;
         sclk_q <= 1'b0;
         act_q  <= 1'b1;
      end else if (act_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q <= 1'b0;
            if (last_bit) begin
               act_q <= 1'b0;
            end else begin
               bcnt_q <= bcnt_q + 1'b1;
               sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/nbw3_align.sv
module nbw3_align #(
   parameter int BYTE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clear,
   output logic wrap
);
   // a word of BYTE_W+1 bits moves the bit position within a byte forward by one
   localparam int PW = $clog2(BYTE_W);
   logic [PW-1:0] phase_q;

   assign wrap = (phase_q == PW'(BYTE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (clear)  phase_q <= '0;
      else if (step)   phase_q <= wrap ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/nbw3_serializer.sv
module nbw3_serializer #(
   parameter int CLK_HZ      = 250_000_000,
   parameter int SCLK_MAX_HZ = 10_000_000,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] filler_op,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_is_data,
   input  logic              in_last,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   output logic              busy
);
   import nbw3_pkg::*;

   localparam int HALF   = half_cycles(CLK_HZ, SCLK_MAX_HZ);
   localparam int WORD_W = BYTE_W + 1;

   generate
      if (CLK_HZ <= 0 || SCLK_MAX_HZ <= 0) begin : g_bad_clk
         $error("clock frequencies must be positive");
      end
      if (BYTE_W < 2) begin : g_bad_width
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   nbw3_state_e       state_q;
   logic              last_q;
   logic              cs_n_q;
   logic              tick, run, active, word_done, wrap;
   logic              accept, pad_load, load;
   logic [WORD_W-1:0] load_word;

   assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_GAP);
   assign accept    = in_valid && in_ready;
   assign pad_load  = (state_q == ST_SHIFT) && word_done && last_q && !wrap;
   assign load      = accept || pad_load;
   assign load_word = accept ? {in_is_data, in_byte} : {1'b0, filler_op};
   assign run       = active || (state_q == ST_CLOSE);
   assign cs_n      = cs_n_q;
   assign busy      = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         last_q  <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_SHIFT;
               cs_n_q  <= 1'b0;
               last_q  <= in_last;
            end
            ST_GAP: if (accept) begin
               state_q <= ST_SHIFT;
               last_q  <= in_last;
            end
            ST_SHIFT: if (word_done) begin
               if (!last_q)   state_q <= ST_GAP;
               else if (wrap) state_q <= ST_CLOSE;
            end
            ST_CLOSE: if (tick) begin
               state_q <= ST_IDLE;
               cs_n_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   nbw3_tick #(.HALF(HALF)) u_tick (
      .clk (clk), .rst_n (rst_n), .run (run), .tick (tick)
   );

   nbw3_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk (clk), .rst_n (rst_n), .load (load), .load_word (load_word),
      .tick (tick), .active (active), .word_done (word_done),
      .sclk (sclk), .mosi (mosi)
   );

   nbw3_align #(.BYTE_W(BYTE_W)) u_align (
      .clk (clk), .rst_n (rst_n), .step (word_done),
      .clear ((state_q == ST_CLOSE) && tick), .wrap (wrap)
   );
endmodule

// File: rtl/nbw3_checker.sv
module nbw3_checker #(
   parameter int BYTE_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic mosi,
   input logic busy,
   input logic in_ready
);
   localparam int PW = $clog2(BYTE_W);
   logic [PW-1:0] rise_mod_q;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_mod_q <= '0;
         sclk_q     <= 1'b0;
      end else begin
         sclk_q <= sclk;
         if (cs_n)
            rise_mod_q <= '0;
         else if (sclk && !sclk_q)
            rise_mod_q <= (rise_mod_q == PW'(BYTE_W - 1)) ? '0 : rise_mod_q + 1'b1;
      end
   end

   assert_byte_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (rise_mod_q == '0));

   assert_release_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !sclk);

   assert_idle_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   assert_ready_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !sclk);

   assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);
endmodule

bind nbw3_serializer nbw3_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk),
   .mosi (mosi), .busy (busy), .in_ready (in_ready)
);

// File: tb/nbw3_serializer_test.sv
module nbw3_serializer_test;
   localparam int EXP_HALF = (250_000_000 + 2 * 10_000_000 - 1) / (2 * 10_000_000);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] filler_op = 8'hE3;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       in_is_data = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready, sclk, cs_n, mosi, busy;

   always #2 clk = ~clk;

   nbw3_serializer uut (
      .clk (clk), .rst_n (rst_n), .filler_op (filler_op),
      .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
      .in_is_data (in_is_data), .in_last (in_last),
      .sclk (sclk), .cs_n (cs_n), .mosi (mosi), .busy (busy)
   );

   int n_tests = 0, n_fail = 0;
   logic cap [0:4095];
   int   cap_n = 0, bursts = 0, bad_hi = 0, bad_mosi = 0, bad_busy = 0, hi_len = 0;
   logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
   logic exp_bits [0:4095];
   int   exp_n;
   logic [7:0] bq [0:31];
   logic       tq [0:31];

   // line monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk && !prev_sclk && !cs_n) begin
            if (cap_n < 4096) cap[cap_n] = mosi;
            cap_n++;
         end
         if (sclk && prev_sclk && mosi != prev_mosi) bad_mosi++;
         if (sclk) hi_len++;
         else begin
            if (prev_sclk && hi_len != EXP_HALF) bad_hi++;
            hi_len = 0;
         end
         if (cs_n && !prev_cs) bursts++;
         if (busy != !cs_n) bad_busy++;
      end
      prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic add_word(input logic flag, input logic [7:0] b);
      exp_bits[exp_n] = flag; exp_n++;
      for (int i = 7; i >= 0; i--) begin
         exp_bits[exp_n] = b[i]; exp_n++;
      end
   endtask

   task automatic push(input int k, input logic last);
      bit ok;
      in_valid = 1'b1; in_byte = bq[k]; in_is_data = tq[k]; in_last = last;
      forever begin
         ok = in_ready;
         @(negedge clk);
         if (ok) break;
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   // send n words with an idle gap between them, then compare the whole stream
   task automatic send(input int n, input int gap, input string req);
      int base, b0, bad;
      base = cap_n; b0 = bursts; exp_n = 0;
      for (int k = 0; k < n; k++) add_word(tq[k], bq[k]);
      while (exp_n % 8 != 0) add_word(1'b0, filler_op);
      for (int k = 0; k < n; k++) begin
         push(k, k == n - 1);
         if (k == 0) check(in_ready == 1'b0, "R8 ready low while shifting", in_ready, 0);
         if (gap > 0 && k < n - 1) begin
            while (!in_ready) @(negedge clk);
            repeat (gap) @(negedge clk);
            check(cs_n == 1'b0 && in_ready == 1'b1, "R11 window held in gap",
                  {cs_n, in_ready}, 1);
         end
      end
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      check(cap_n - base == exp_n, {req, " stream length"}, cap_n - base, exp_n);
      bad = -1;
      for (int i = 0; i < exp_n && i < cap_n - base; i++)
         if (bad < 0 && cap[base + i] !== exp_bits[i]) bad = i;
      check(bad < 0, {req, " R2 bit order, first bad bit index"}, bad, -1);
      check(bursts - b0 == 1, "R6 one chip-select window", bursts - b0, 1);
      check((cap_n - base) % 8 == 0, "R4 byte aligned", (cap_n - base) % 8, 0);
   endtask

   task automatic t_reset;
      check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
      check(sclk == 1'b0, "R1 sclk", sclk, 0);
      check(busy == 1'b0, "R1 busy", busy, 0);
      check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
   endtask

   task automatic t_single_cmd;
      int base;
      base = cap_n;
      filler_op = 8'hE3;
      bq[0] = 8'hA5; tq[0] = 1'b0;
      send(1, 0, "R4 single command");
      check(cap_n - base == 72, "R4 seven filler words", cap_n - base, 72);
      check(cap[base] == 1'b0, "R3 command tag", cap[base], 0);
   endtask

   task automatic t_cmd_data;
      filler_op = 8'hE3;
      bq[0] = 8'h15; tq[0] = 1'b0;
      bq[1] = 8'h00; tq[1] = 1'b1;
      bq[2] = 8'h7F; tq[2] = 1'b1;
      send(3, 40, "R2 command with data");
   endtask

   task automatic t_eight_words;
      int base;
      base = cap_n;
      filler_op = 8'hE3;
      bq[0] = 8'hC3; tq[0] = 1'b0;
      for (int k = 1; k < 8; k++) begin bq[k] = 8'(k * 37); tq[k] = 1'b1; end
      send(8, 0, "R5 aligned burst");
      check(cap_n - base == 72, "R5 no filler", cap_n - base, 72);
   endtask

   task automatic t_filler_change;
      filler_op = 8'h5C;
      bq[0] = 8'h81; tq[0] = 1'b0;
      bq[1] = 8'hFF; tq[1] = 1'b1;
      bq[2] = 8'h01; tq[2] = 1'b1;
      send(3, 0, "R10 new filler opcode");
   endtask

   task automatic t_data_only;
      int base;
      base = cap_n;
      filler_op = 8'hE3;
      for (int k = 0; k < 20; k++) begin bq[k] = 8'(8'h3A ^ (k * 11)); tq[k] = 1'b1; end
      send(20, 0, "R3 data-only burst");
      check(cap_n - base == 216, "R4 four filler words", cap_n - base, 216);
      check(cap[base] == 1'b1, "R3 data tag", cap[base], 1);
   endtask

   task automatic t_timing;
      check(bad_hi == 0, "R7 high phase length", bad_hi, 0);
      check(bad_mosi == 0, "R7 mosi stable while sclk high", bad_mosi, 0);
      check(bad_busy == 0, "R9 busy follows window", bad_busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_cmd();
      t_cmd_data();
      t_eight_words();
      t_filler_change();
      t_data_only();
      t_timing();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule